// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the software-visible control state of one bus-master disk channel: a command byte, a status byte and a 32-bit descriptor table base address. All three sit behind a small byte-addressable register port. Reads return data combinationally. Writes take effect at the clock edge on which the write strobe is sampled. The block does not move data. It turns edges of the command start bit into a one-cycle start pulse and a level stop request for a separate DMA engine. It reloads the current descriptor pointer from the base register, tracks whether the channel is active, and follows the engine's idle and completion reports.

The block also sits in the interrupt path from the drive. A rising drive interrupt sets a sticky status flag and raises the host interrupt. A falling drive interrupt lowers the host interrupt only. Software clears the sticky flag by writing a one to it.

The port has three locations. Offset 0 is the command byte. Offset 2 is the status byte. Offsets 4 to 7 hold the table base, little-endian. The size code gives the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Write data is right-aligned, so byte 0 of the data lands on the addressed offset.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write to offset 0 keeps only data bit 0 (start) and data bit 3 (direction). Reading offset 0 returns those two bits in the same positions, with every other bit zero. The direction bit drives `cmdDir`.
- R2: A command write whose start bit equals the stored start bit leaves the start pulse low, the current pointer unchanged and the active flag unchanged.
- R3: A command write that takes start from 0 to 1 loads `tablePtr` from the base register. If the active flag was clear, the write also sets it and pulses `engStart` high for exactly the one cycle after the write. If the active flag was already set, no pulse occurs and any pending stop is withdrawn.
- R4: A command write that takes start from 1 to 0 while `engIdle` is high clears the active flag at that edge. If `engIdle` is low, `stopReq` rises and the active flag stays set until a cycle in which `engIdle` is high. The flag clears at that edge and `stopReq` falls with it.
- R5: A write at offsets 4..7 changes only the base bytes it addresses, according to the offset and the size code. Bytes beyond offset 7 are dropped. Base bits 1:0 always read as zero.
- R6: A read at offset 4+k returns the base shifted right by 8*k bits, masked to the access width.
- R7: A rising `drvIrq` sets status bit 2 and raises `hostIrq` one cycle later. A falling `drvIrq` lowers `hostIrq` one cycle later and leaves status bit 2 as it was.
- R8: The status byte at offset 2 is laid out as follows: bit 0 is active, bit 1 is error, bit 2 is interrupt, and the other bits read as zero. Writing 1 to bit 1 or bit 2 clears that bit. Writes have no effect on bit 0.
- R9: An `engDone` pulse clears the active flag unless `engMore` is high. If `engErr` is high during the pulse, status bit 1 is set.
- R10: Reset clears the command, status, base and current pointer, withdraws any stop request, and holds `engStart` and `hostIrq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Byte offset of the access |
| regSize | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| regWdata | input | 32 | Right-aligned write data |
| regRdata | output | 32 | Right-aligned read data (combinational) |
| drvIrq | input | 1 | Interrupt level from the drive |
| engIdle | input | 1 | DMA engine has no transfer in flight |
| engDone | input | 1 | Engine completion pulse |
| engMore | input | 1 | Qualifies `engDone`: more data still expected |
| engErr | input | 1 | Qualifies `engDone`: transfer ended in error |
| engStart | output | 1 | One-cycle start command to the engine |
| stopReq | output | 1 | Stop requested; waiting for the engine to go idle |
| tableBase | output | 32 | Descriptor table base address |
| tablePtr | output | 32 | Current descriptor pointer |
| cmdDir | output | 1 | Transfer direction bit |
| hostIrq | output | 1 | Interrupt to the host |

## Verification
The bench targets these corner cases:

- A second write of an unchanged start bit. A design that acts on level instead of edge would pulse `engStart` again or reload the pointer.
- Restarting while the channel is still active. A faulty design would issue a second start, or fail to withdraw a pending stop.
- A stop issued while the engine is busy. A design that aborts would drop the active flag before `engIdle` rises.
- Narrow and unaligned base writes, including ones that run past offset 7. Lane errors corrupt neighbouring bytes or let bits 1:0 through.
- A falling drive interrupt. A faulty design would clear the sticky interrupt flag along with the host line.

// File: rtl/dmaCtlPkg.sv
package dmaCtlPkg;
  localparam int CMD_OFF  = 0;
  localparam int STAT_OFF = 2;
  localparam int BASE_OFF = 4;
  localparam int START_BIT = 0;
  localparam int DIR_BIT   = 3;

  typedef struct packed {
    logic loadPtr;
    logic setActive;
    logic clrActive;
  } ctlStrobe_t;
endpackage

// File: rtl/dma_ctl_ctrl.sv
module dma_ctl_ctrl
  import dmaCtlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       wrStart,
  input  logic       curStart,
  input  logic       active,
  input  logic       engIdle,
  input  logic       engDone,
  input  logic       engMore,
  output ctlStrobe_t strobe,
  output logic       engStart,
  output logic       stopReq
);
  logic startRise, startFall, stopPending;

  assign startRise = cmdWr && wrStart && !curStart;
  assign startFall = cmdWr && !wrStart && curStart;

  always_comb begin
    strobe.loadPtr   = startRise;
    strobe.setActive = startRise && !active;
    strobe.clrActive = !startRise &&
                       ((startFall && engIdle) ||
                        (stopPending && engIdle) ||
                        (engDone && !engMore));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopPending <= 1'b0;
      engStart    <= 1'b0;
    end else begin
      engStart <= strobe.setActive;
      if (startRise || engIdle)
        stopPending <= 1'b0;
      else if (startFall)
        stopPending <= 1'b1;
    end
  end

  assign stopReq = stopPending;

  // R2: unchanged start bit never produces a start command
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (wrStart == curStart)) |=> !engStart);

  // R4: pending stop keeps the channel active while the engine is busy
  a_r4_stop_waits: assert property (@(posedge clk) disable iff (!rstN)
    (stopPending && !engIdle && !engDone) |=> active);

  // R9: completion without more data ends activity
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && !engMore && !startRise) |=> !active);
endmodule

// File: rtl/dma_ctl_dp.sv
module dma_ctl_dp
  import dmaCtlPkg::*;
#(
  parameter int TBL_AW = 32,
  parameter int REG_AW = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        regSize,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  ctlStrobe_t        strobe,
  input  logic              engDone,
  input  logic              engErr,
  input  logic              drvIrq,
  output logic              cmdStart,
  output logic              cmdDir,
  output logic              active,
  output logic [TBL_AW-1:0] tableBase,
  output logic [TBL_AW-1:0] tablePtr,
  output logic              hostIrq
);
  localparam int NB = TBL_AW / 8;

  logic              errSt, intSt;
  logic [TBL_AW-1:0] baseNext;
  logic              statWr, cmdWr, baseSel, irqRise;
  int                offInt, nBytes;
  logic [DATA_W-1:0] rdMask;

  assign cmdWr   = regWr && (int'(regAddr) == CMD_OFF);
  assign statWr  = regWr && (int'(regAddr) == STAT_OFF);
  assign baseSel = int'(regAddr) >= BASE_OFF;
  assign offInt  = int'(regAddr) - BASE_OFF;
  assign irqRise = drvIrq && !hostIrq;

  always_comb begin
    case (regSize)
      2'd0:    begin nBytes = 1; rdMask = DATA_W'(32'h0000_00FF); end
      2'd1:    begin nBytes = 2; rdMask = DATA_W'(32'h0000_FFFF); end
      default: begin nBytes = 4; rdMask = {DATA_W{1'b1}}; end
    endcase
  end

  always_comb begin
    baseNext = tableBase;
    if (regWr && baseSel) begin
      for (int l = 0; l < NB; l++) begin
        if (l >= offInt && l < offInt + nBytes)
          baseNext[8*l +: 8] = regWdata[8*(l-offInt) +: 8];
      end
    end
    baseNext[1:0] = 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdStart  <= 1'b0;
      cmdDir    <= 1'b0;
      active    <= 1'b0;
      errSt     <= 1'b0;
      intSt     <= 1'b0;
      tableBase <= '0;
      tablePtr  <= '0;
      hostIrq   <= 1'b0;
    end else begin
      if (cmdWr) begin
        cmdStart <= regWdata[START_BIT];
        cmdDir   <= regWdata[DIR_BIT];
      end
      tableBase <= baseNext;
      if (strobe.loadPtr) tablePtr <= tableBase;
      if (strobe.setActive) active <= 1'b1;
      else if (strobe.clrActive) active <= 1'b0;
      if (engDone && engErr) errSt <= 1'b1;
      else if (statWr && regWdata[1]) errSt <= 1'b0;
      if (irqRise) intSt <= 1'b1;
      else if (statWr && regWdata[2]) intSt <= 1'b0;
      hostIrq <= drvIrq;
    end
  end

  always_comb begin
    regRdata = '0;
    if (int'(regAddr) == CMD_OFF)
      regRdata = DATA_W'({4'b0, cmdDir, 2'b0, cmdStart});
    else if (int'(regAddr) == STAT_OFF)
      regRdata = DATA_W'({5'b0, intSt, errSt, active});
    else if (baseSel)
      regRdata = DATA_W'(tableBase >> (8 * offInt)) & rdMask;
  end

  // R3: a start strobe loads the pointer from the base and activates
  a_r3_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setActive |=> (active && tablePtr == $past(tableBase)));

  // R7: the host line only rises with the sticky flag set
  a_r7_rise_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> intSt);

  // R7: a low drive line lowers the host line next cycle
  a_r7_fall_follow: assert property (@(posedge clk) disable iff (!rstN)
    !drvIrq |=> !hostIrq);

  // R5: the low base bits never hold ones
  a_r5_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> (regRdata != 32'h3 || int'($past(regAddr)) != BASE_OFF || tableBase[1:0] == 2'b00));
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dmaCtlPkg::*;
#(
  parameter int TBL_AW = 32,
  parameter int REG_AW = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        regSize,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              drvIrq,
  input  logic              engIdle,
  input  logic              engDone,
  input  logic              engMore,
  input  logic              engErr,
  output logic              engStart,
  output logic              stopReq,
  output logic [TBL_AW-1:0] tableBase,
  output logic [TBL_AW-1:0] tablePtr,
  output logic              cmdDir,
  output logic              hostIrq
);
  ctlStrobe_t strobe;
  logic       cmdStart, active, cmdWr;

  assign cmdWr = regWr && (int'(regAddr) == CMD_OFF);

  dma_ctl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWr    (cmdWr),
    .wrStart  (regWdata[START_BIT]),
    .curStart (cmdStart),
    .active   (active),
    .engIdle  (engIdle),
    .engDone  (engDone),
    .engMore  (engMore),
    .strobe   (strobe),
    .engStart (engStart),
    .stopReq  (stopReq)
  );

  dma_ctl_dp #(.TBL_AW(TBL_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regSize   (regSize),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .strobe    (strobe),
    .engDone   (engDone),
    .engErr    (engErr),
    .drvIrq    (drvIrq),
    .cmdStart  (cmdStart),
    .cmdDir    (cmdDir),
    .active    (active),
    .tableBase (tableBase),
    .tablePtr  (tablePtr),
    .hostIrq   (hostIrq)
  );
endmodule

// File: tb/dma_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module dma_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [1:0]  regSize = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        drvIrq = 1'b0, engIdle = 1'b1, engDone = 1'b0, engMore = 1'b0, engErr = 1'b0;
  logic        engStart, stopReq, cmdDir, hostIrq;
  logic [31:0] tableBase, tablePtr;

  int total = 0;
  int bad = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  dma_ctl_regs dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regSize(regSize),
    .regWdata(regWdata), .regRdata(regRdata), .drvIrq(drvIrq), .engIdle(engIdle),
    .engDone(engDone), .engMore(engMore), .engErr(engErr), .engStart(engStart),
    .stopReq(stopReq), .tableBase(tableBase), .tablePtr(tablePtr), .cmdDir(cmdDir),
    .hostIrq(hostIrq)
  );

  function automatic logic [31:0] baseAfter(logic [31:0] old, int off, int sz, logic [31:0] d);
    logic [31:0] r = old;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int i = 0; i < n; i++)
      if (off + i < 4) r[8*(off+i) +: 8] = d[8*i +: 8];
    r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [31:0] baseRead(logic [31:0] m, int off, int sz);
    logic [31:0] v = m >> (8 * off);
    if (sz == 0) return v & 32'hFF;
    if (sz == 1) return v & 32'hFFFF;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int sz, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'(addr); regSize = 2'(sz); regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(int addr, int sz, output logic [31:0] d);
    regAddr = 3'(addr); regSize = 2'(sz);
    #1 d = regRdata;
  endtask

  task automatic pulseDone(logic more, logic err);
    @(negedge clk);
    engDone = 1'b1; engMore = more; engErr = err;
    @(negedge clk);
    engDone = 1'b0; engMore = 1'b0; engErr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rd(0, 0, d); chk("R10 cmd reset", d, 0);
    rd(2, 0, d); chk("R10 status reset", d, 0);
    rd(4, 2, d); chk("R10 base reset", d, 0);
    chk("R10 outputs reset", {engStart, stopReq, hostIrq, tablePtr}, 0);
    rstN = 1'b1;

    // R1: only start and direction kept
    wr(0, 0, 32'hF6); rd(0, 0, d); chk("R1 masked bits", d, 0);
    wr(0, 0, 32'h08); rd(0, 0, d); chk("R1 dir kept", d, 32'h08);
    chk("R1 cmdDir", cmdDir, 1);

    // R5/R6 directed
    wr(4, 2, 32'hFFFF_FFFF); rd(4, 2, d); chk("R5 low bits zero", d, 32'hFFFF_FFFC);
    model = 32'hFFFF_FFFC;
    wr(7, 2, 32'h0000_005A); model = baseAfter(model, 3, 2, 32'h5A);
    rd(4, 2, d); chk("R5 overhang dropped", d, model);
    rd(6, 1, d); chk("R6 two-byte read", d, baseRead(model, 2, 1));

    // R5/R6 random
    for (int i = 0; i < 300; i++) begin
      int off = $urandom_range(3, 0);
      int sz = $urandom_range(2, 0);
      logic [31:0] v = $urandom;
      wr(4 + off, sz, v);
      model = baseAfter(model, off, sz, v);
      off = $urandom_range(3, 0);
      sz = $urandom_range(2, 0);
      rd(4 + off, sz, d);
      chk("R6 random read", d, baseRead(model, off, sz));
    end
    chk("R5 base port", tableBase, model);

    // R3 start from idle
    wr(4, 2, 32'h1234_5678);
    engIdle = 1'b1;
    wr(0, 0, 32'h01);
    chk("R3 start pulse", engStart, 1);
    chk("R3 pointer load", tablePtr, 32'h1234_5678);
    rd(2, 0, d); chk("R3 active set", d & 1, 1);
    @(negedge clk); chk("R3 pulse one cycle", engStart, 0);

    // R2 same start value
    wr(4, 2, 32'hAABB_CC00);
    wr(0, 0, 32'h01);
    chk("R2 no pulse", engStart, 0);
    chk("R2 pointer kept", tablePtr, 32'h1234_5678);
    wr(0, 0, 32'h09);
    chk("R2 pointer kept dir", tablePtr, 32'h1234_5678);
    rd(2, 0, d); chk("R2 active kept", d & 1, 1);

    // R9 completion
    pulseDone(1'b1, 1'b0);
    rd(2, 0, d); chk("R9 more keeps active", d, 32'h01);
    pulseDone(1'b0, 1'b1);
    rd(2, 0, d); chk("R9 done clears, error set", d, 32'h02);

    // R8 W1C
    wr(2, 0, 32'h02); rd(2, 0, d); chk("R8 error cleared", d, 0);

    // R4 stop while idle, then stop while busy
    wr(0, 0, 32'h00); chk("R4 idle stop no request", stopReq, 0);
    wr(0, 0, 32'h01); chk("R3 restart pulse", engStart, 1);
    engIdle = 1'b0;
    wr(0, 0, 32'h00);
    chk("R4 stop request", stopReq, 1);
    repeat (3) @(negedge clk);
    rd(2, 0, d); chk("R4 active held while busy", d & 1, 1);
    wr(2, 0, 32'hFF); rd(2, 0, d); chk("R8 active read-only", d & 1, 1);

    // R3 restart while still active
    wr(4, 2, 32'h0000_F000);
    wr(0, 0, 32'h01);
    chk("R3 no pulse when active", engStart, 0);
    chk("R3 reload when active", tablePtr, 32'h0000_F000);
    chk("R3 stop withdrawn", stopReq, 0);

    // R4 stop completes when engine goes idle
    wr(0, 0, 32'h00);
    chk("R4 stop request again", stopReq, 1);
    engIdle = 1'b1;
    @(negedge clk);
    rd(2, 0, d); chk("R4 active cleared on idle", d & 1, 0);
    chk("R4 stop dropped", stopReq, 0);

    // R7 interrupts
    drvIrq = 1'b1;
    @(negedge clk);
    chk("R7 host irq high", hostIrq, 1);
    rd(2, 0, d); chk("R7 int flag set", d, 32'h04);
    drvIrq = 1'b0;
    @(negedge clk);
    chk("R7 host irq low", hostIrq, 0);
    rd(2, 0, d); chk("R7 int flag kept", d, 32'h04);
    wr(2, 0, 32'h04); rd(2, 0, d); chk("R8 int cleared", d, 0);

    // R10 reset mid-activity
    engIdle = 1'b0;
    wr(0, 0, 32'h09);
    wr(0, 0, 32'h08);
    drvIrq = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    rd(0, 0, d); chk("R10 cmd cleared", d, 0);
    rd(2, 0, d); chk("R10 status cleared", d, 0);
    chk("R10 base and pointer", {tableBase, tablePtr}, 0);
    chk("R10 stop, start and irq", {stopReq, engStart, hostIrq}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule